// File: doc/BRIEF.md
# Converter Command Slave for a Two-Wire Bus

This block is the serial front end of an eight-channel, 12-bit sampling converter. It sits on a two-wire bus as a slave. SCL and SDA reach it through synchronizers in the system clock domain. It watches for start and stop conditions and decodes a 7-bit address. On a write it accepts a command byte. On a read it returns the latest conversion result.

A write carries the command. When the command byte arrives, the block publishes the input-mode bit, the channel number and the power field to the converter core. It also pulses a start strobe partway through that byte. The core answers with a result word and a done flag, and the block keeps that result until a read collects it. A read returns the result as a high byte, whose upper four bits are zero padding, followed by a low byte. The block drives the bus only by pulling SDA low through an enable output.

Top module: `adc_cmd_slave`

## Requirements
- R1: The 7-bit address is binary 10010 followed by the two latched strap bits, with strap bit 1 above strap bit 0. The eighth bit gives the direction: 1 is read, 0 is write. On a mismatch the block does not acknowledge, and it ignores every clock until the next start condition.
- R2: The strap inputs are latched on the first clock after reset is released. Later changes on them do not alter the address the block answers to.
- R3: After a matching address byte, and after every command byte, the block pulls SDA low from the eighth falling SCL edge to the ninth falling SCL edge. It begins pulling SDA low only while SCL is low.
- R4: The command byte is received MSB first. Bit 7 is the input mode (1 means single-ended, 0 means differential), bits 6:4 are the channel number, bits 3:2 are the power field, and bits 1:0 are ignored. The mode and channel outputs update together with the start strobe. The power field updates when the eighth bit has been received.
- R5: During a write-addressed transfer, the start strobe is high for exactly one system clock when the fourth command bit (bit 4) is sampled. A read transfer never raises it.
- R6: A read sends two bytes, MSB first. The first is four zeros followed by result bits 11:8. The second is result bits 7:0. The result is the value present on the last clock the done flag was high.
- R7: When the master does not acknowledge a read byte, SDA stays released on every further clock until a start condition.
- R8: When the master acknowledges the second read byte, the block sends the first byte again, and it keeps alternating between the two bytes.
- R9: A start condition in the middle of any transfer abandons that transfer and begins a new address phase.
- R10: A stop condition releases SDA and returns the block to idle. Bytes clocked after the stop with no new start get no acknowledge.
- R11: After reset, SDA is released, the start strobe is low, and the mode, channel and power outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Address strap pins, latched after reset |
| conv_result_i | input | RES_W (12) | Conversion result from the core |
| conv_done_i | input | 1 | Result valid, captures conv_result_i |
| conv_start_o | output | 1 | One-clock conversion start strobe |
| single_ended_o | output | 1 | Input mode, 1 = single-ended |
| chan_o | output | 3 | Selected channel number |
| pwr_mode_o | output | 2 | Power field from the command byte |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, prefix 10010 and a 12-bit result. The bus clock runs at one quarter-phase every eight system clocks, so the synchronizer latency never overlaps an SCL phase. With a 12-bit result, both the zero padding and the split at result bit 8 are visible in the read bytes. The default two-bit strap lets the bench move the answering address after reset and confirm that the latched value stays in force.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 2;
  localparam int PREFIX_W = 5;
  localparam int CHAN_W = 3;
  localparam int PWR_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/adcs_sync_bit.sv
module adcs_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adcs_bus_events.sv
module adcs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave
  import adcs_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [PREFIX_W-1:0]   ADDR_PREFIX = 5'b10010,
  parameter int                    RES_W       = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [RES_W-1:0]   conv_result_i,
  input  logic               conv_done_i,
  output logic               conv_start_o,
  output logic               single_ended_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [PWR_W-1:0]   pwr_mode_o
);
  localparam int HI_BITS  = RES_W - BYTE_W;
  localparam int PAD_BITS = BYTE_W - HI_BITS;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_CMD4 = CNT_W'(3);

  // line synchronizers
  logic [1:0] raw_lines, sync_lines;
  assign raw_lines = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    adcs_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_lines[g]), .q(sync_lines[g]));
  end
  logic scl_s, sda_s;
  assign scl_s = sync_lines[0];
  assign sda_s = sync_lines[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  adcs_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  // strap latch and result holding register
  logic [STRAP_W-1:0] strap_q;
  logic               strap_ok_q;
  logic [RES_W-1:0]   held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_ok_q <= 1'b0;
    end else if (!strap_ok_q) begin
      strap_q    <= strap_i;
      strap_ok_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_q <= '0;
    else if (conv_done_i) held_q <= conv_result_i;
  end

  logic [BYTE_W-1:0] hi_byte, lo_byte, next_byte;
  assign hi_byte = {{PAD_BITS{1'b0}}, held_q[RES_W-1:BYTE_W]};
  assign lo_byte = held_q[BYTE_W-1:0];

  // protocol state
  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shr_q, shr_d, txsh_q, txsh_d;
  logic              rw_q, rw_d, oe_q, oe_d, bsel_q, bsel_d, cs_q, cs_d;
  logic              sd_q, sd_d;
  logic [CHAN_W-1:0] ch_q, ch_d;
  logic [PWR_W-1:0]  pd_q, pd_d;

  assign next_byte = bsel_q ? lo_byte : hi_byte;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    txsh_d  = txsh_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    bsel_d  = bsel_q;
    cs_d    = 1'b0;
    sd_d    = sd_q;
    ch_d    = ch_q;
    pd_d    = pd_q;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (shr_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_q}) begin
              oe_d    = 1'b1;
              rw_d    = shr_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              txsh_d  = hi_byte;
              oe_d    = ~hi_byte[BYTE_W-1];
              bsel_d  = 1'b1;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (scl_rise) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_CMD4) begin
              cs_d = 1'b1;
              sd_d = shr_q[2];
              ch_d = {shr_q[1:0], sda_s};
            end
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            oe_d    = 1'b1;
            pd_d    = shr_q[3:2];
            state_d = ST_CMD_ACK;
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_CMD;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              cnt_d  = cnt_q + 1'b1;
              oe_d   = ~txsh_q[BYTE_W-2];
              txsh_d = {txsh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_WAIT;
          end else if (scl_fall) begin
            cnt_d   = '0;
            txsh_d  = next_byte;
            oe_d    = ~next_byte[BYTE_W-1];
            bsel_d  = ~bsel_q;
            state_d = ST_TX;
          end
        end
        ST_IDLE, ST_WAIT: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      txsh_q  <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      bsel_q  <= 1'b0;
      cs_q    <= 1'b0;
      sd_q    <= 1'b0;
      ch_q    <= '0;
      pd_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      txsh_q  <= txsh_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      bsel_q  <= bsel_d;
      cs_q    <= cs_d;
      sd_q    <= sd_d;
      ch_q    <= ch_d;
      pd_q    <= pd_d;
    end
  end

  assign sda_pull_o     = oe_q;
  assign conv_start_o   = cs_q;
  assign single_ended_o = sd_q;
  assign chan_o         = ch_q;
  assign pwr_mode_o     = pd_q;

  // assertions
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_pull_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  assert_fields_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({single_ended_o, chan_o}) |-> conv_start_o);

  assert_release_for_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK) |-> !sda_pull_o);

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_WAIT) |-> !sda_pull_o);
endmodule

// File: tb/adc_cmd_slave_test.sv
module adc_cmd_slave_test;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h94;  // strap 10, write
  localparam logic [7:0] AR = 8'h95;  // strap 10, read
  localparam int NVEC = 6;
  // {command byte, result}
  localparam logic [19:0] VECS [NVEC] = '{
    20'h8CABC, 20'h70000, 20'hFCFFF, 20'h245A3, 20'hD8801, 20'h4317F };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_low_m = 1'b0;
  logic [1:0] strap = 2'b10;
  logic [11:0] result = '0;
  logic done_f = 1'b0;
  logic sda_pull, conv_start, single_ended;
  logic [2:0] chan;
  logic [1:0] pwr;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  int conv_count = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = ~(sda_low_m | sda_pull);

  adc_cmd_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .strap_i(strap), .conv_result_i(result),
    .conv_done_i(done_f), .conv_start_o(conv_start),
    .single_ended_o(single_ended), .chan_o(chan), .pwr_mode_o(pwr));

  always @(posedge clk) if (rst_n && conv_start) conv_count++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_low_m = 1'b1; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_low_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_low_m = 1'b0; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_low_m = ~b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_low_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_low_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      v[i] = sda_bus; wq();
      scl_m = 1'b0; wq();
    end
    sda_low_m = mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_low_m = 1'b0;
  endtask

  task automatic load_result(input logic [11:0] r);
    @(negedge clk); result = r; done_f = 1'b1;
    @(negedge clk); done_f = 1'b0;
  endtask

  initial begin
    logic ack;
    logic [7:0] b0, b1, b2;
    int cc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 sda released", sda_pull, 0);
    chk("R11 start low", conv_start, 0);
    chk("R11 mode/channel", {single_ended, chan}, 0);
    chk("R11 power field", pwr, 0);

    // vector table: write a command, load a result, read it back
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] cmd;
      logic [11:0] res;
      cmd = VECS[v][19:12];
      res = VECS[v][11:0];
      cc = conv_count;
      bus_start();
      write_byte(AW, ack);  chk("R1 write address ack", ack, 1);
      write_byte(cmd, ack); chk("R3 command ack", ack, 1);
      chk("R5 one start strobe", conv_count - cc, 1);
      chk("R4 mode bit", single_ended, cmd[7]);
      chk("R4 channel", chan, cmd[6:4]);
      chk("R4 power field", pwr, cmd[3:2]);
      load_result(res);
      bus_start();
      write_byte(AR, ack);  chk("R1 read address ack", ack, 1);
      read_byte(1'b1, b0);  chk("R6 high byte", b0, {4'b0, res[11:8]});
      read_byte(1'b0, b1);  chk("R6 low byte", b1, res[7:0]);
      bus_stop();
      chk("R5 no strobe on read", conv_count - cc, 1);
    end

    // R1 wrong address: no ack, following byte ignored
    cc = conv_count;
    bus_start();
    write_byte(8'h96, ack); chk("R1 mismatch nack", ack, 0);
    write_byte(8'h00, ack); chk("R1 ignored byte nack", ack, 0);
    bus_stop();
    chk("R1 no strobe after mismatch", conv_count - cc, 0);
    chk("R1 channel kept", chan, 3'b100);

    // R9 repeated start after two command bits, then R8 wrap, R7 release
    bus_start();
    write_byte(AW, ack); chk("R9 write address ack", ack, 1);
    send_bit(1'b1);
    send_bit(1'b0);
    bus_start();
    write_byte(AR, ack); chk("R9 read address ack after restart", ack, 1);
    read_byte(1'b1, b0); chk("R9 high byte", b0, 8'h01);
    read_byte(1'b1, b1); chk("R8 low byte", b1, 8'h7F);
    read_byte(1'b0, b2); chk("R8 wrap to high byte", b2, 8'h01);
    read_byte(1'b0, b2); chk("R7 released after nack", b2, 8'hFF);
    bus_stop();
    chk("R5 no strobe for partial/read", conv_count - cc, 0);

    // R10 stop mid-command, then a byte without start
    bus_start();
    write_byte(AW, ack); chk("R10 address ack", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    chk("R5 strobe at fourth bit", conv_count - cc, 1);
    chk("R4 channel at fourth bit", {single_ended, chan}, 4'b1010);
    bus_stop();
    scl_m = 1'b0; wq();
    write_byte(8'h00, ack); chk("R10 no ack after stop", ack, 0);
    bus_stop();

    // R2 strap latched after reset only
    rst_n = 1'b0; strap = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 2'b01;
    repeat (3) @(negedge clk);
    bus_start();
    write_byte(AW, ack); chk("R2 latched strap still answers", ack, 1);
    bus_stop();
    bus_start();
    write_byte(8'h92, ack); chk("R2 new strap ignored", ack, 0);
    bus_stop();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule